// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Router

This block collects interrupt requests from a set of peripheral sources and steers each one onto one of nine general-purpose priority lines of a core event controller, numbered level 7 (most urgent of the nine) up to level 15. Every source owns a 4-bit offset field. The offset, added to 7, names the level that source drives, so software sets a source's effective priority by rewriting its field. A per-source enable bit gates the request before routing. Each level line is the registered OR of all enabled sources steered to it.

A plain synchronous register port holds the configuration. The packed offset fields come first, eight per 32-bit word, with source i in word i/8, bits 4*(i%8)+3 down to 4*(i%8). The enable words follow, then the read-only raw status words, which show the unmasked source inputs. Reset loads a fixed map: the error sources go to level 7, the real-time-clock source goes to level 8, and the DMA completion sources go to level 9.

Top module: `irq_router`

## Requirements
- R1: After reset, lvl_irq is 0 and every enable bit is 0. Offset fields read 0 for sources 0..14 (error group), 1 for source 15 (real-time clock) and 2 for sources 16..23 (DMA completions). With the defaults this gives words 0x00000000, 0x10000000 and 0x22222222 at addresses 0, 1 and 2.
- R2: lvl_irq bit k stands for level 7+k. On each clock edge it takes the OR of all sources i with src_irq[i]=1, enable bit i = 1 and offset field i equal to k. It is visible one cycle after the source is sampled.
- R3: The offset field of source i is at address i/8, bits 4*(i%8)+3 down to 4*(i%8).
- R4: Offset values 9 through 15 steer the source to no level.
- R5: Enable bit i (address 3, bit i) gates source i. A disabled source drives no level.
- R6: A write lands on the clock edge where wr_en is sampled high. The outputs follow the new configuration from the next edge on, so after the write edge lvl_irq still shows the old routing for one cycle.
- R7: Reading address 4 returns the raw src_irq value, enable bits not applied, with bits above the source count reading 0. rd_data is registered and shows the word of the rd_addr sampled at the previous edge.
- R8: Reads of addresses 0..3 return the stored words. Writes to address 4 and to unmapped addresses 5..7 change no stored word.
- R9: Several sources steered to one level merge by OR. Sources on different levels raise their own bits independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | NUM_SRC (24) | Raw peripheral interrupt requests |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W (3) | Register read address |
| rd_data | output | 32 | Registered read data |
| lvl_irq | output | 9 | Registered level lines, bit k is level 7+k |

## Verification
The hardest case to reach from the ports is the one-cycle window between a configuration write and the first output edge that uses it. The output must still show the old routing there, and that window only exists while a source is held active across the write. The bench keeps one source asserted, rewrites its offset field, and samples lvl_irq on the cycle right after the write edge and again one cycle later. The unrouted offsets and the ignored writes to the status and unmapped addresses are shown the same way: the bench reads back every stored word, or watches the level lines, before it applies the next stimulus.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int NUM_LVL        = 9;   // general-purpose levels 7..15
  localparam int FIELD_W        = 4;
  localparam int WORD_W         = 32;
  localparam int FIELDS_PER_REG = WORD_W / FIELD_W;

  typedef logic [NUM_LVL-1:0] lvl_vec_t;
  typedef logic [FIELD_W-1:0] offset_t;

  // Power-on offset for one field slot
  function automatic offset_t default_offset(input int idx, input int n_src,
                                             input int n_err, input int rtc_idx);
    if (idx >= n_src)   return offset_t'(15);  // unused slot: unrouted
    if (idx < n_err)    return offset_t'(0);   // error group -> level 7
    if (idx == rtc_idx) return offset_t'(1);   // real-time clock -> level 8
    return offset_t'(2);                       // DMA completions -> level 9
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int ADDR_W  = 3,
  parameter int NUM_ERR = 15,
  parameter int RTC_IDX = 15,
  localparam int NA     = (NUM_SRC + FIELDS_PER_REG - 1) / FIELDS_PER_REG,
  localparam int NE     = (NUM_SRC + WORD_W - 1) / WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  output logic [NA*WORD_W-1:0] asg_flat,
  output logic [NE*WORD_W-1:0] en_flat
);

  localparam int EN_BASE = NA;
  localparam int ST_BASE = NA + NE;

  function automatic logic [NA*WORD_W-1:0] build_default();
    logic [NA*WORD_W-1:0] v;
    v = '0;
    for (int f = 0; f < NA * FIELDS_PER_REG; f++)
      v[f*FIELD_W +: FIELD_W] = default_offset(f, NUM_SRC, NUM_ERR, RTC_IDX);
    return v;
  endfunction

  localparam logic [NA*WORD_W-1:0] DEF_ASG = build_default();

  logic [WORD_W-1:0] asg_r [NA];
  logic [WORD_W-1:0] en_r  [NE];
  logic              rst_d;

  for (genvar g = 0; g < NA; g++) begin : g_asg
    always_ff @(posedge clk) begin
      if (rst)
        asg_r[g] <= DEF_ASG[g*WORD_W +: WORD_W];
      else if (wr_en && wr_addr == ADDR_W'(g))
        asg_r[g] <= wr_data;
    end
    assign asg_flat[g*WORD_W +: WORD_W] = asg_r[g];

    // R6: a write to an offset word is captured on its edge
    a_r6_asg_capture: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(g)) |=> (asg_r[g] == $past(wr_data)));
  end

  for (genvar e = 0; e < NE; e++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst)
        en_r[e] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(EN_BASE + e))
        en_r[e] <= wr_data;
    end
    assign en_flat[e*WORD_W +: WORD_W] = en_r[e];

    // R5: a write to an enable word is captured on its edge
    a_r5_en_capture: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(EN_BASE + e)) |=> (en_r[e] == $past(wr_data)));
  end

  always_ff @(posedge clk) rst_d <= rst;

  // R1: first cycle after reset shows the power-on map with all sources disabled
  a_r1_default_map: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (asg_flat == DEF_ASG && en_flat == '0));

  // R8: writes at or above the status address leave the configuration untouched
  a_r8_ignore_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= ADDR_W'(ST_BASE)) |=> ($stable(asg_flat) && $stable(en_flat)));

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 24,
  localparam int NA     = (NUM_SRC + FIELDS_PER_REG - 1) / FIELDS_PER_REG
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   src_irq,
  input  logic [NA*WORD_W-1:0] asg_flat,
  input  logic [NUM_SRC-1:0]   en_bits,
  output lvl_vec_t             lvl_q
);

  offset_t  offs  [NUM_SRC];
  lvl_vec_t route [NUM_SRC];
  lvl_vec_t hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign offs[i] = asg_flat[i*FIELD_W +: FIELD_W];
    // offsets 9..15 match no level, so such a source drives nothing
    always_comb begin
      for (int k = 0; k < NUM_LVL; k++)
        route[i][k] = src_irq[i] & en_bits[i] & (offs[i] == offset_t'(k));
    end
  end

  always_comb begin
    hit = '0;
    for (int i = 0; i < NUM_SRC; i++)
      hit = hit | route[i];
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= hit;
  end

  // R2: a raised level needs an enabled active source on the previous edge
  a_r2_needs_source: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != '0) |-> $past(|(src_irq & en_bits)));

  // R5: with every source disabled no level rises on the next edge
  a_r5_all_masked: assert property (@(posedge clk) disable iff (rst)
    (en_bits == '0) |=> (lvl_q == '0));

endmodule

// File: rtl/irq_status_read.sv
module irq_status_read
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int ADDR_W  = 3,
  localparam int NA     = (NUM_SRC + FIELDS_PER_REG - 1) / FIELDS_PER_REG,
  localparam int NE     = (NUM_SRC + WORD_W - 1) / WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [NUM_SRC-1:0]   src_irq,
  input  logic [NA*WORD_W-1:0] asg_flat,
  input  logic [NE*WORD_W-1:0] en_flat,
  output logic [WORD_W-1:0]    rd_data
);

  localparam int EN_BASE = NA;
  localparam int ST_BASE = NA + NE;
  localparam int SW      = NE * WORD_W;

  logic [SW-1:0]     src_pad;
  logic [WORD_W-1:0] word;

  assign src_pad = SW'(src_irq);

  always_comb begin
    word = '0;
    for (int g = 0; g < NA; g++)
      if (rd_addr == ADDR_W'(g)) word = asg_flat[g*WORD_W +: WORD_W];
    for (int e = 0; e < NE; e++) begin
      if (rd_addr == ADDR_W'(EN_BASE + e)) word = en_flat[e*WORD_W +: WORD_W];
      if (rd_addr == ADDR_W'(ST_BASE + e)) word = src_pad[e*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= word;
  end

  // R7: the first status word mirrors the raw sources of the previous edge
  a_r7_status_raw: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == ADDR_W'(ST_BASE)) |=> (rd_data == $past(src_pad[WORD_W-1:0])));

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int ADDR_W  = 3,
  parameter int NUM_ERR = 15,
  parameter int RTC_IDX = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [31:0]        rd_data,
  output logic [8:0]         lvl_irq
);

  localparam int NA = (NUM_SRC + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
  localparam int NE = (NUM_SRC + WORD_W - 1) / WORD_W;

  logic [NA*WORD_W-1:0] asg_flat;
  logic [NE*WORD_W-1:0] en_flat;
  lvl_vec_t             lvl_q;

  irq_cfg_regs #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .NUM_ERR(NUM_ERR), .RTC_IDX(RTC_IDX)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .asg_flat(asg_flat), .en_flat(en_flat)
  );

  irq_level_map #(.NUM_SRC(NUM_SRC)) u_map (
    .clk(clk), .rst(rst), .src_irq(src_irq), .asg_flat(asg_flat),
    .en_bits(en_flat[NUM_SRC-1:0]), .lvl_q(lvl_q)
  );

  irq_status_read #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_addr(rd_addr), .src_irq(src_irq),
    .asg_flat(asg_flat), .en_flat(en_flat), .rd_data(rd_data)
  );

  assign lvl_irq = lvl_q;

endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC       = 24;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_irq = '0;
  logic            wr_en = 1'b0;
  logic [2:0]      wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [2:0]      rd_addr = '0;
  logic [31:0]     rd_data;
  logic [8:0]      lvl_irq;

  int total = 0;
  int bad   = 0;

  irq_router u_irq_router (
    .clk(clk), .rst(rst), .src_irq(src_irq), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .lvl_irq(lvl_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {src pattern, expected levels} under the power-on map, all sources enabled
  localparam logic [32:0] VEC [8] = '{
    {24'h000000, 9'h000},
    {24'h000001, 9'h001},
    {24'h004000, 9'h001},
    {24'h008000, 9'h002},
    {24'h010000, 9'h004},
    {24'h800000, 9'h004},
    {24'hFFFFFF, 9'h007},
    {24'h008001, 9'h003}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    tick();
    d = rd_data;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    check("R1 lvl after reset", 32'(lvl_irq), 32'h0);
    rd(3'd0, v); check("R1 word0 default", v, 32'h00000000);
    rd(3'd1, v); check("R1 word1 default", v, 32'h10000000);
    rd(3'd2, v); check("R1 word2 default", v, 32'h22222222);
    rd(3'd3, v); check("R1 enable default", v, 32'h0);

    // R5 all disabled: nothing routes; R7 status still raw
    src_irq = 24'hFFFFFF;
    rd(3'd4, v);
    check("R5 masked sources drive no level", 32'(lvl_irq), 32'h0);
    check("R7 status shows raw sources", v, 32'h00FFFFFF);

    // R2 table under default map
    wr(3'd3, 32'h00FFFFFF);
    for (int n = 0; n < 8; n++) begin
      src_irq = VEC[n][32:9];
      tick();
      check($sformatf("R2 vector %0d", n), 32'(lvl_irq), 32'(VEC[n][8:0]));
    end

    // R6 / R3: field of source 1 at bits 7:4 of word 0, held source across write
    src_irq = 24'h000002;
    tick();
    check("R6 before write", 32'(lvl_irq), 32'h001);
    wr(3'd0, 32'h00000080);
    check("R6 old routing one cycle after write edge", 32'(lvl_irq), 32'h001);
    tick();
    check("R3 offset 8 at bits 7:4 drives level 15", 32'(lvl_irq), 32'h100);

    // R4 unrouted offsets
    wr(3'd0, 32'h00000090); tick();
    check("R4 offset 9 routes nowhere", 32'(lvl_irq), 32'h000);
    wr(3'd0, 32'h000000F0); tick();
    check("R4 offset 15 routes nowhere", 32'(lvl_irq), 32'h000);

    // R9 merge and independence; R3 source 23 at word 2 bits 31:28
    wr(3'd0, 32'h00000000);
    wr(3'd2, 32'h52222222);
    src_irq = 24'h808003;
    tick();
    check("R9 OR on level 7 plus independent levels", 32'(lvl_irq), 32'h023);

    // R5 single source gated
    wr(3'd3, 32'h00FF7FFF);
    src_irq = 24'h008000;
    tick();
    check("R5 disabled source 15 drives nothing", 32'(lvl_irq), 32'h000);
    rd(3'd4, v);
    check("R7 status shows disabled source", v, 32'h00008000);

    // R8 writes to status / unmapped ignored
    wr(3'd4, 32'hFFFFFFFF);
    wr(3'd5, 32'hFFFFFFFF);
    wr(3'd7, 32'hFFFFFFFF);
    rd(3'd0, v); check("R8 word0 unchanged", v, 32'h00000000);
    rd(3'd2, v); check("R8 word2 unchanged", v, 32'h52222222);
    rd(3'd3, v); check("R8 enable unchanged", v, 32'h00FF7FFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule